// File: doc/BRIEF.md
# Enhanced Parallel Port Host Cycle Engine

This block is the host end of an Enhanced Parallel Port link. A local requester asks for one bus cycle at a time: a data write, a data read, an address write or an address read. The engine then runs the handshake on the parallel cable. It puts the direction on the write line (`strobe_n`), pulses one of two strobe lines, waits for the peripheral to raise `busy`, and releases the strobe as its acknowledgment. It also drives the byte and its output enable during writes. When the cycle ends it returns the captured byte for reads, together with a one-cycle completion pulse.

The `busy` line comes from outside the clock domain, so two flops synchronize it before the sequencer uses it. A run-time limit guards the wait for `busy`. If the peripheral stays silent for too long, the engine drops its strobes, finishes the cycle and raises an error flag. A fresh request is accepted only after the peripheral has dropped `busy` from the previous cycle.

Top module: `epp_host_engine`

## Requirements
- R1: A write cycle holds `strobe_n` low and `pd_oe` high with `pd_out` equal to the requested byte while the strobe is asserted. A read cycle keeps `strobe_n` high and `pd_oe` low throughout.
- R2: `req_kind` bit 0 set means read and bit 1 set means address. A data cycle pulls `autofd_n` low, while an address cycle pulls `hselect_n` low. At most one of the two is low at any time, and both are high outside a cycle.
- R3: `req_ready` is low while the synchronized `busy` is high. A request is then not taken and no strobe is asserted. A strobe only begins after `busy` has been seen low.
- R4: Once asserted, the strobe stays low until `busy` is observed high. The release comes on the third falling clock edge after `busy` rises, because of the two synchronizer flops and the state register.
- R5: A read latches `pd_in` at the clock edge where the strobe is released. It holds that value on `rd_data` from the completion pulse until the next read.
- R6: The cycle after the strobe is released, `done` is high for exactly one cycle. At that point `strobe_n` is high and `pd_oe` is low.
- R7: If `tmo_limit` is non-zero and `busy` stays low for `tmo_limit` cycles after the strobe asserts, the strobe is released (it is low for `tmo_limit`+1 falling edges), `done` pulses and `err` rises. The next accepted request clears `err`. A limit of zero waits forever.
- R8: After reset the engine is idle. Both strobes and `strobe_n` are high, `pd_oe`, `done` and `err` are low, and `req_ready` is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Cycle request |
| req_kind | input | 2 | Bit 0: read, bit 1: address |
| req_wdata | input | 8 | Byte for write cycles |
| tmo_limit | input | 16 | Wait limit in cycles, 0 disables |
| req_ready | output | 1 | Engine can take a request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last cycle timed out |
| rd_data | output | 8 | Byte captured by the last read |
| strobe_n | output | 1 | Direction line, low for writes |
| autofd_n | output | 1 | Data strobe, active low |
| hselect_n | output | 1 | Address strobe, active low |
| busy | input | 1 | Peripheral wait/acknowledge, asynchronous |
| pd_in | input | 8 | Data bus as seen from the cable |
| pd_out | output | 8 | Data bus drive value |
| pd_oe | output | 1 | Data bus output enable |

## Verification
Some properties are checked by assertions on every cycle. These are the exclusivity of the two strobes, the absence of bus drive during a read strobe, the hold of a strobe until `busy` or the limit, the single-cycle width of `done`, and the coincidence of a rising `err` with `done`. Other behaviour can only be shown by the bench scenarios. This covers the exact three-edge release latency, the byte captured on reads, and the refusal of requests while `busy` lingers. It also covers the strobe width under a timeout, the clearing of `err` by the next cycle, and the unlimited wait when the limit is zero.

// File: rtl/epp_pkg.sv
package epp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_REL  = 2'd2
  } epp_state_e;

  localparam int KIND_RD_BIT   = 0;
  localparam int KIND_ADDR_BIT = 1;
endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/epp_tmo.sv
module epp_tmo #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign expired = (limit != '0) && (cnt_q >= limit);
  assign cnt_en  = clr || (run && !expired);

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/epp_host_engine.sv
module epp_host_engine
  import epp_pkg::*;
#(
  parameter int DW          = 8,
  parameter int TMO_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [DW-1:0]    req_wdata,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             req_ready,
  output logic             done,
  output logic             err,
  output logic [DW-1:0]    rd_data,
  output logic             strobe_n,
  output logic             autofd_n,
  output logic             hselect_n,
  input  logic             busy,
  input  logic [DW-1:0]    pd_in,
  output logic [DW-1:0]    pd_out,
  output logic             pd_oe
);
  logic rst_int_n;
  logic busy_s;

  epp_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_int_n)
  );

  epp_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (busy),
    .q     (busy_s)
  );

  epp_state_e        state_q, state_d;
  logic [1:0]        kind_q;
  logic [DW-1:0]     wdata_q;
  logic [DW-1:0]     rdata_q;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              accept, capture, abort, tmo_hit;
  logic              line_on, in_cycle, is_rd, is_addr;

  assign accept  = req_valid && req_ready;
  assign capture = (state_q == ST_WAIT) && busy_s;
  assign abort   = (state_q == ST_WAIT) && !busy_s && tmo_hit;

  epp_tmo #(.CNT_W(TMO_W)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (accept),
    .run     (state_q == ST_WAIT),
    .limit   (tmo_limit),
    .expired (tmo_hit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept)  state_d = ST_WAIT;
      ST_WAIT: begin
        if (busy_s)       state_d = ST_REL;
        else if (tmo_hit) state_d = ST_IDLE;
      end
      ST_REL:             state_d = ST_IDLE;
      default:            state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    done_d = (state_q == ST_REL) || abort;
    err_d  = err_q;
    if (accept)     err_d = 1'b0;
    else if (abort) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      kind_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      kind_q  <= req_kind;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)                    rdata_q <= '0;
    else if (capture && kind_q[KIND_RD_BIT]) rdata_q <= pd_in;
  end

  assign is_rd    = kind_q[KIND_RD_BIT];
  assign is_addr  = kind_q[KIND_ADDR_BIT];
  assign line_on  = (state_q == ST_WAIT);
  assign in_cycle = (state_q == ST_WAIT) || (state_q == ST_REL);

  assign req_ready = (state_q == ST_IDLE) && !busy_s;
  assign autofd_n  = !(line_on && !is_addr);
  assign hselect_n = !(line_on && is_addr);
  assign strobe_n  = !(in_cycle && !is_rd);
  assign pd_oe     = in_cycle && !is_rd;
  assign pd_out    = wdata_q;
  assign done      = done_q;
  assign err       = err_q;
  assign rd_data   = rdata_q;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(!autofd_n && !hselect_n)); // R2

  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((!autofd_n || !hselect_n) && strobe_n) |-> !pd_oe); // R1

  AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((!autofd_n || !hselect_n) && !busy_s && !tmo_hit) |=> (!autofd_n || !hselect_n)); // R4

  AST_STROBE_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(autofd_n && hselect_n) |-> $past(!busy_s)); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !done); // R6

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(err) |-> done); // R7
endmodule

// File: tb/epp_host_engine_test.sv
module epp_host_engine_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [7:0]  req_wdata;
  logic [15:0] tmo_limit;
  logic        req_ready, done, err;
  logic [7:0]  rd_data;
  logic        strobe_n, autofd_n, hselect_n;
  logic        busy;
  logic [7:0]  pd_in;
  logic [7:0]  pd_out;
  logic        pd_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  epp_host_engine uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_wdata(req_wdata), .tmo_limit(tmo_limit), .req_ready(req_ready),
    .done(done), .err(err), .rd_data(rd_data), .strobe_n(strobe_n),
    .autofd_n(autofd_n), .hselect_n(hselect_n), .busy(busy), .pd_in(pd_in),
    .pd_out(pd_out), .pd_oe(pd_oe)
  );

  // {kind[1:0], write byte, read byte}
  localparam logic [17:0] VEC [6] = '{
    {2'b00, 8'hA5, 8'h00},
    {2'b01, 8'h00, 8'h3C},
    {2'b10, 8'h5A, 8'h00},
    {2'b11, 8'h00, 8'hC3},
    {2'b00, 8'hFF, 8'h00},
    {2'b11, 8'h00, 8'h01}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit line_low();
    return !autofd_n || !hselect_n;
  endfunction

  task automatic issue(input logic [1:0] k, input logic [7:0] w);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (req_ready) break;
    end
    req_kind  = k;
    req_wdata = w;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // After issue(): peripheral answers and checks the whole cycle.
  task automatic serve(input logic [1:0] k, input logic [7:0] w, input logic [7:0] r);
    int lat;
    bit rd  = k[0];
    bit adr = k[1];
    for (int i = 0; i < 100 && !line_low(); i++) @(negedge clk);
    check(line_low(), "R2 strobe asserted", 0, 1);
    check(adr ? (!hselect_n && autofd_n) : (!autofd_n && hselect_n), "R2 strobe line",
          {autofd_n, hselect_n}, adr ? 2 : 1);
    check(strobe_n == rd, "R1 direction", strobe_n, rd);
    check(pd_oe == !rd, "R1 output enable", pd_oe, !rd);
    if (!rd) check(pd_out == w, "R1 write byte", pd_out, w);
    busy  = 1'b1;
    pd_in = r;
    lat = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      lat++;
      if (!line_low()) break;
    end
    check(lat == 3, "R4 release latency", lat, 3);
    for (int i = 0; i < 10 && !done; i++) @(negedge clk);
    check(done, "R6 done pulse", done, 1);
    check(strobe_n && !pd_oe, "R6 bus idle at done", {strobe_n, pd_oe}, 2);
    check(!err, "R7 no error", err, 0);
    if (rd) check(rd_data == r, "R5 read byte", rd_data, r);
    check(!req_ready, "R3 ready low while busy", req_ready, 0);
    @(negedge clk);
    check(!done, "R6 done one cycle", done, 0);
    busy  = 1'b0;
    pd_in = 8'h00;
    if (rd) begin
      repeat (4) @(negedge clk);
      check(rd_data == r, "R5 read byte held", rd_data, r);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int cnt;
    rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_wdata = '0;
    tmo_limit = 16'd0; busy = 1'b0; pd_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(autofd_n && hselect_n && strobe_n, "R8 lines idle", {autofd_n, hselect_n, strobe_n}, 7);
    check(!pd_oe && !done && !err, "R8 flags low", {pd_oe, done, err}, 0);
    check(req_ready, "R8 ready", req_ready, 1);

    for (int v = 0; v < 6; v++) begin
      issue(VEC[v][17:16], VEC[v][15:8]);
      serve(VEC[v][17:16], VEC[v][15:8], VEC[v][7:0]);
    end

    // R3: busy high while idle blocks requests
    busy = 1'b1;
    repeat (4) @(negedge clk);
    check(!req_ready, "R3 ready with busy", req_ready, 0);
    req_kind = 2'b00; req_wdata = 8'h11; req_valid = 1'b1;
    cnt = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (line_low()) cnt++;
    end
    check(cnt == 0, "R3 no strobe while busy", cnt, 0);
    req_valid = 1'b0;
    busy = 1'b0;
    repeat (4) @(negedge clk);
    check(autofd_n && hselect_n && strobe_n, "R3 request dropped", {autofd_n, hselect_n, strobe_n}, 7);

    // R7: timeout with limit 6
    tmo_limit = 16'd6;
    issue(2'b10, 8'h77);
    cnt = 0;
    for (int i = 0; i < 30 && !done; i++) begin
      if (line_low()) cnt++;
      @(negedge clk);
    end
    check(cnt == 7, "R7 strobe width on timeout", cnt, 7);
    check(done && err, "R7 abort flags", {done, err}, 3);
    check(hselect_n && strobe_n && !pd_oe, "R7 lines released", {hselect_n, strobe_n, pd_oe}, 6);
    @(negedge clk);
    check(err, "R7 error held", err, 1);
    issue(2'b01, 8'h00);
    check(!err, "R7 error cleared by accept", err, 1'b0);
    serve(2'b01, 8'h00, 8'h9E);

    // R7: zero limit waits forever
    tmo_limit = 16'd0;
    issue(2'b00, 8'h42);
    cnt = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (line_low() && !done) cnt++;
    end
    check(cnt == 60, "R7 no timeout at limit 0", cnt, 60);
    serve(2'b00, 8'h42, 8'h00);

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule